// File: doc/BRIEF.md
# Hot-Swap Fault Retry Supervisor

This block decides, cycle by cycle, whether the pass switch of a 48 V inrush-limited input path may conduct. It qualifies raw undervoltage and overvoltage comparator outputs with separate set and clear dwell times, and watches a current-limit-active flag, a hard-fault flag and a power-good input. A fault timer bounds how long the switch may sit in current limit during start-up and while conducting.

Faults fall into two classes. A hard fault (short-circuit flag or qualified overvoltage) latches the switch off until an explicit clear. A benign fault (qualified undervoltage, or fault-timer expiry) turns the switch off for a minimum off-time and then retries, up to a bounded number of retries; one more benign fault after that latches. Every retry and latch emits a one-cycle event strobe with a reason code and advances a saturating event counter, so a site controller can log the timeline. The analog ramp, current sensing and gate drive sit outside this block.

The control pins are plain levels; the event output is a strobe with no back-pressure, because the events are rare and a logger that misses one can still read the running event count.

Top module: `hsw_supervisor`

## Requirements
- R1: While reset is asserted and just after it, gate_en, fault and latched are 0, retry_cnt, evt_cnt and evt_code are 0; the undervoltage qualifier starts in the asserted state.
- R2: A raw undervoltage or overvoltage input is acted on only after it differs from its qualified value for DEB_SET consecutive cycles (to assert) or DEB_CLR consecutive cycles (to clear); a shorter pulse has no effect on any output.
- R3: From the idle off state, gate_en rises one cycle after the undervoltage qualifier clears; it never rises while undervoltage is qualified.
- R4: During start-up without power-good, gate_en stays high for exactly T_FLT+1 cycles of current limit, then the fault timer expiry is handled as a benign fault with reason code 4.
- R5: Power-good seen in start-up before timer expiry moves the block to normal conduction and resets the fault timer; gate_en then stays high while current limit is absent.
- R6: After a retry event, gate_en stays low for at least T_OFF cycles; with healthy input it is low for exactly T_OFF+2 sampled cycles before the next start-up.
- R7: Each benign fault increments retry_cnt; a benign fault arriving when retry_cnt equals MAX_RETRY latches with reason code 5 and leaves retry_cnt at MAX_RETRY.
- R8: hard_in forces gate_en low in the same cycle it asserts, and the block is latched after the next clock edge with reason code 1.
- R9: A qualified overvoltage latches the block with reason code 2.
- R10: A qualified undervoltage while the switch is enabled is a benign fault with reason code 3.
- R11: The latched state (fault=1, latched=1, gate_en=0) is left only by clear_in, which returns the block to the off state and zeroes retry_cnt; input voltage changes do not unlatch it, and clear_in outside the latched state has no effect.
- R12: retry_cnt returns to 0 one cycle after the switch has been in normal conduction for T_GOOD cycles.
- R13: Each retry or latch event raises evt_stb for exactly one cycle, loads evt_code with a nonzero reason and increments evt_cnt by one (saturating).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_in | input | 1 | Raw undervoltage comparator output |
| ov_in | input | 1 | Raw overvoltage comparator output |
| ilim_in | input | 1 | Switch is in current limit |
| hard_in | input | 1 | Hard-fault flag (persistent short) |
| pgood_in | input | 1 | Output power-good |
| clear_in | input | 1 | Service clear of the latched state |
| gate_en | output | 1 | Pass-switch enable |
| fault | output | 1 | Switch held off by a fault (cool-down or latched) |
| latched | output | 1 | Latched off awaiting clear |
| retry_cnt | output | RW | Retries since last good period or clear |
| evt_stb | output | 1 | One-cycle event strobe |
| evt_code | output | 3 | Reason of the last event: 1 hard, 2 overvoltage, 3 undervoltage, 4 timer, 5 retry limit |
| evt_cnt | output | EW | Saturating count of retry and latch events |

## Verification
The assertions watch, on every cycle, that a latched block stays latched without a clear, that a hard fault always leads to the latch, that the retry count never passes its limit, that cool-down is not cut short, that an expired start-up timer always leaves start-up, and that qualifier outputs only flip after the full dwell count. The exact durations of enable and off windows, the reason codes carried by each fault kind, the good-time clearing of the retry count, and the rejection of short comparator glitches are shown only by the bench's scenarios, which count sampled cycles against values computed from the parameters.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_ON    = 3'd2,
    ST_COOL  = 3'd3,
    ST_LATCH = 3'd4
  } hsw_state_e;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_HARD  = 3'd1,
    RSN_OV    = 3'd2,
    RSN_UV    = 3'd3,
    RSN_TIMER = 3'd4,
    RSN_LIMIT = 3'd5
  } hsw_reason_e;
endpackage

// File: rtl/hsw_debounce.sv
module hsw_debounce #(
  parameter int SET_CYC = 4,
  parameter int CLR_CYC = 4,
  parameter bit INIT    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic q
);
  localparam int MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] SET_L = W'(SET_CYC - 1);
  localparam logic [W-1:0] CLR_L = W'(CLR_CYC - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  // dwell to assert differs from dwell to clear: hysteresis in time
  assign lim = q ? CLR_L : SET_L;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= INIT;
      cnt <= '0;
    end else if (raw == q) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      q   <= raw;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the qualified level flips only after a full dwell
  assert_deb_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q != $past(q)) |-> ($past(cnt) == $past(lim) && $past(raw) == q));
endmodule

// File: rtl/hsw_tick.sv
module hsw_tick #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_L = W'(LIMIT);

  logic [W-1:0] cnt;

  assign done = (cnt == LIM_L);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsw_supervisor.sv
module hsw_supervisor
  import hsw_pkg::*;
#(
  parameter int DEB_SET   = 4,
  parameter int DEB_CLR   = 4,
  parameter int T_FLT     = 16,
  parameter int T_OFF     = 20,
  parameter int T_GOOD    = 32,
  parameter int MAX_RETRY = 3,
  parameter int EW        = 8,
  localparam int RW       = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uv_in,
  input  logic          ov_in,
  input  logic          ilim_in,
  input  logic          hard_in,
  input  logic          pgood_in,
  input  logic          clear_in,
  output logic          gate_en,
  output logic          fault,
  output logic          latched,
  output logic [RW-1:0] retry_cnt,
  output logic          evt_stb,
  output logic [2:0]    evt_code,
  output logic [EW-1:0] evt_cnt
);
  localparam logic [RW-1:0] RMAX = RW'(MAX_RETRY);

  hsw_state_e  st, nx;
  hsw_reason_e rsn, brsn;
  logic uv_q, ov_q;
  logic flt_clr, flt_done, off_done, good_done;
  logic ev, bump, clr_r, benign;

  hsw_debounce #(.SET_CYC(DEB_SET), .CLR_CYC(DEB_CLR), .INIT(1'b1)) u_uv (
    .clk(clk), .rst_n(rst_n), .raw(uv_in), .q(uv_q));
  hsw_debounce #(.SET_CYC(DEB_SET), .CLR_CYC(DEB_CLR), .INIT(1'b0)) u_ov (
    .clk(clk), .rst_n(rst_n), .raw(ov_in), .q(ov_q));

  // start-up limit time is cumulative; in conduction only a continuous run counts
  assign flt_clr = !(st == ST_START || st == ST_ON)
                 || (st == ST_START && pgood_in)
                 || (st == ST_ON && !ilim_in);

  hsw_tick #(.LIMIT(T_FLT)) u_flt (
    .clk(clk), .rst_n(rst_n), .clr(flt_clr), .run(ilim_in), .done(flt_done));
  hsw_tick #(.LIMIT(T_OFF)) u_off (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_COOL), .run(1'b1), .done(off_done));
  hsw_tick #(.LIMIT(T_GOOD)) u_good (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_ON), .run(1'b1), .done(good_done));

  always_comb begin
    nx     = st;
    ev     = 1'b0;
    bump   = 1'b0;
    clr_r  = 1'b0;
    benign = 1'b0;
    rsn    = RSN_NONE;
    brsn   = RSN_NONE;
    if (st != ST_LATCH && (hard_in || ov_q)) begin
      nx  = ST_LATCH;
      ev  = 1'b1;
      rsn = hard_in ? RSN_HARD : RSN_OV;
    end else begin
      unique case (st)
        ST_OFF:   if (!uv_q) nx = ST_START;
        ST_START: begin
          if (uv_q) begin benign = 1'b1; brsn = RSN_UV; end
          else if (flt_done) begin benign = 1'b1; brsn = RSN_TIMER; end
          else if (pgood_in) nx = ST_ON;
        end
        ST_ON: begin
          if (uv_q) begin benign = 1'b1; brsn = RSN_UV; end
          else if (flt_done) begin benign = 1'b1; brsn = RSN_TIMER; end
        end
        ST_COOL:  if (off_done) nx = ST_OFF;
        ST_LATCH: if (clear_in) begin nx = ST_OFF; clr_r = 1'b1; end
        default:  nx = ST_OFF;
      endcase
      if (benign) begin
        ev = 1'b1;
        if (retry_cnt == RMAX) begin
          nx  = ST_LATCH;
          rsn = RSN_LIMIT;
        end else begin
          nx   = ST_COOL;
          rsn  = brsn;
          bump = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      retry_cnt <= '0;
      evt_stb   <= 1'b0;
      evt_code  <= RSN_NONE;
      evt_cnt   <= '0;
    end else begin
      st      <= nx;
      evt_stb <= ev;
      if (ev) evt_code <= rsn;
      if (ev && evt_cnt != '1) evt_cnt <= evt_cnt + 1'b1;
      if (clr_r) retry_cnt <= '0;
      else if (bump) retry_cnt <= retry_cnt + 1'b1;
      else if (st == ST_ON && good_done) retry_cnt <= '0;
    end
  end

  assign gate_en = (st == ST_START || st == ST_ON) && !hard_in;
  assign fault   = (st == ST_COOL) || (st == ST_LATCH);
  assign latched = (st == ST_LATCH);

  assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH && !clear_in) |=> (st == ST_LATCH));
  assert_hard_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hard_in |=> latched);
  assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RMAX);
  assert_cool_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL && !off_done && !hard_in && !ov_q) |=> (st == ST_COOL));
  assert_timer_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && flt_done) |=> (st != ST_START));
  assert_evt_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> (evt_code != RSN_NONE));
endmodule

// File: tb/sim_hsw_supervisor.sv
module sim_hsw_supervisor;
  localparam int CLK_NS    = 10;
  localparam int DEB_SET   = 4;
  localparam int DEB_CLR   = 4;
  localparam int T_FLT     = 16;
  localparam int T_OFF     = 20;
  localparam int T_GOOD    = 32;
  localparam int MAX_RETRY = 3;
  localparam int EW        = 8;
  localparam int RW        = $clog2(MAX_RETRY + 1);

  logic clk = 1'b0;
  logic rst_n, uv_in, ov_in, ilim_in, hard_in, pgood_in, clear_in;
  logic gate_en, fault, latched, evt_stb;
  logic [RW-1:0] retry_cnt;
  logic [2:0]    evt_code;
  logic [EW-1:0] evt_cnt;

  int total = 0;
  int bad   = 0;

  always #(CLK_NS/2) clk = ~clk;

  hsw_supervisor #(.DEB_SET(DEB_SET), .DEB_CLR(DEB_CLR), .T_FLT(T_FLT), .T_OFF(T_OFF),
                   .T_GOOD(T_GOOD), .MAX_RETRY(MAX_RETRY), .EW(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_in(uv_in), .ov_in(ov_in), .ilim_in(ilim_in),
    .hard_in(hard_in), .pgood_in(pgood_in), .clear_in(clear_in), .gate_en(gate_en),
    .fault(fault), .latched(latched), .retry_cnt(retry_cnt), .evt_stb(evt_stb),
    .evt_code(evt_code), .evt_cnt(evt_cnt));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts samples (including the current one) while gate_en holds level lv
  task automatic run_len(input logic lv, output int n);
    n = 0;
    while (gate_en == lv && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; uv_in = 1'b1; ov_in = 1'b0; ilim_in = 1'b0;
    hard_in = 1'b0; pgood_in = 1'b0; clear_in = 1'b0;
    step(3);
    // R1: reset state
    chk("R1 gate", int'(gate_en), 0);
    chk("R1 fault", int'(fault), 0);
    chk("R1 latched", int'(latched), 0);
    chk("R1 retry", int'(retry_cnt), 0);
    chk("R1 evtcnt", int'(evt_cnt), 0);
    chk("R1 code", int'(evt_code), 0);
    rst_n = 1'b1;
    step(10);
    chk("R3 no start under uv", int'(gate_en), 0);

    // R2/R3: start DEB_CLR+1 cycles after uv clears
    uv_in = 1'b0;
    n = 0;
    while (!gate_en && n < 100) begin @(negedge clk); n++; end
    chk("R3 start delay", n, DEB_CLR + 1);

    // R4/R6/R7: retries under persistent current limit
    ilim_in = 1'b1;
    for (int k = 1; k <= MAX_RETRY; k++) begin
      run_len(1'b1, n);
      chk("R4 limit window", n, T_FLT + 1);
      chk("R4 timer code", int'(evt_code), 4);
      chk("R7 retry count", int'(retry_cnt), k);
      chk("R6 fault in cool", int'(fault), 1);
      run_len(1'b0, n);
      chk("R6 off window", n, T_OFF + 2);
    end
    run_len(1'b1, n);
    chk("R4 last window", n, T_FLT + 1);
    chk("R7 latched", int'(latched), 1);
    chk("R7 limit code", int'(evt_code), 5);
    chk("R7 retry held", int'(retry_cnt), MAX_RETRY);
    chk("R13 evt count", int'(evt_cnt), MAX_RETRY + 1);

    // R11: input changes do not unlatch
    ilim_in = 1'b0;
    step(50);
    uv_in = 1'b1; step(10); uv_in = 1'b0; step(10);
    chk("R11 still latched", int'(latched), 1);
    chk("R11 gate off", int'(gate_en), 0);
    chk("R11 fault", int'(fault), 1);
    clear_in = 1'b1; step(1); clear_in = 1'b0;
    chk("R11 cleared", int'(latched), 0);
    chk("R11 retry zeroed", int'(retry_cnt), 0);
    step(1);
    chk("R11 restart", int'(gate_en), 1);

    // R5/R12: one retry, then power-good start-up
    ilim_in = 1'b1;
    run_len(1'b1, n);
    chk("R4 second run", n, T_FLT + 1);
    run_len(1'b0, n);
    chk("R6 second off", n, T_OFF + 2);
    step(10);
    pgood_in = 1'b1; ilim_in = 1'b0;
    step(T_GOOD + 1);
    chk("R5 conduct", int'(gate_en), 1);
    chk("R12 before good", int'(retry_cnt), 1);
    step(1);
    chk("R12 after good", int'(retry_cnt), 0);

    // R2: short uv glitch ignored
    uv_in = 1'b1; step(DEB_SET - 1); uv_in = 1'b0;
    step(10);
    chk("R2 uv glitch gate", int'(gate_en), 1);
    chk("R2 uv glitch evt", int'(evt_cnt), MAX_RETRY + 2);

    // R10: qualified brownout, clear_in ignored while cooling
    uv_in = 1'b1;
    n = 0;
    while (gate_en && n < 100) begin @(negedge clk); n++; end
    chk("R10 uv delay", n, DEB_SET + 1);
    chk("R10 uv code", int'(evt_code), 3);
    chk("R10 retry", int'(retry_cnt), 1);
    uv_in = 1'b0;
    n = 0;
    clear_in = 1'b1;
    while (!gate_en && n < 1000) begin n++; @(negedge clk); clear_in = 1'b0; end
    chk("R6 brownout off", n, T_OFF + 2);
    chk("R11 clear ignored", int'(retry_cnt), 1);

    // R8/R13: hard fault
    step(3);
    hard_in = 1'b1;
    #1;
    chk("R8 same cycle", int'(gate_en), 0);
    chk("R8 not yet latched", int'(latched), 0);
    @(negedge clk);
    chk("R8 latched", int'(latched), 1);
    chk("R8 code", int'(evt_code), 1);
    chk("R13 strobe", int'(evt_stb), 1);
    hard_in = 1'b0;
    step(1);
    chk("R13 strobe one", int'(evt_stb), 0);
    step(5);
    chk("R11 hard held", int'(latched), 1);
    clear_in = 1'b1; step(1); clear_in = 1'b0;
    step(3);

    // R2/R9: overvoltage glitch then sustained
    ov_in = 1'b1; step(DEB_SET - 1); ov_in = 1'b0;
    step(10);
    chk("R2 ov glitch", int'(latched), 0);
    ov_in = 1'b1;
    n = 0;
    while (!latched && n < 100) begin @(negedge clk); n++; end
    chk("R9 ov delay", n, DEB_SET + 1);
    chk("R9 code", int'(evt_code), 2);
    ov_in = 1'b0;
    step(20);
    chk("R11 ov held", int'(latched), 1);
    chk("R13 total events", int'(evt_cnt), MAX_RETRY + 5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule